// File: doc/BRIEF.md
# Multi-CPU Interrupt Priority Arbiter

This block keeps the per-interrupt state of an interrupt distributor: enable, pending, sampled input level, trigger type, an 8-bit priority, and, for shared interrupts, a mask of target CPUs. Up to eight CPUs share it. For every CPU it finds the enabled and pending interrupt with the lowest numeric priority. It publishes that ID as the CPU's highest-pending value and drives one request line per CPU. Two gates stand between the winner and the request line. The winner must beat the CPU's priority mask, and it must also beat the priority of the interrupt the CPU is already servicing.

IDs 0 to 31 are private: each CPU has its own copy of their state and its own 32 input lines. IDs from 32 up to `NUM_IRQ-1` are shared and reach the CPUs named in their target mask. A command port sets and clears enables and pending bits, and writes priority, trigger type and targets. A register decoder and the acknowledge/completion logic drive this port. The global enable, the per-CPU enables, the priority masks and the running priorities come in as plain inputs. A mode input picks legacy or generic handling of rising level-triggered inputs.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset every `hp_id` slice reads 1023 and `irq_req` is all zero; all enable, pending, level, trigger and target state is zero and all priorities are 0.
- R2: A CPU's candidates are the interrupts that are both enabled and pending for it. The lowest numeric priority wins, and on equal priority the lowest ID wins.
- R3: When no interrupt is both enabled and pending for a CPU, its `hp_id` slice is 1023 and its request is low.
- R4: When `dist_en` or the CPU's `cpu_en` bit was low at the previous clock edge, that CPU's request is low and its `hp_id` is 1023.
- R5: The winner is published only if its priority is strictly below the CPU's 8-bit mask. The request is raised only if the priority is also strictly below the CPU's 9-bit running priority (0x100 means idle).
- R6: A rising edge on the input line of an edge-triggered interrupt sets it pending in both modes. An input that holds its level sets nothing, so a pending bit cleared while the line stays high stays clear.
- R7: On a rising input of a level-triggered interrupt, legacy mode (`legacy_mode`=1) sets pending if the interrupt is enabled for that CPU. Generic mode (`legacy_mode`=0) does not set it.
- R8: For IDs 0 to 31, enable, pending, priority and level are per CPU. Command writes touch only CPU `cmd_cpu`, and private line bit `c*32+j` drives ID j of CPU c.
- R9: For IDs 32 and up, pending is set only for the CPUs whose bit is set in the target mask. Line bit `i-32` of `line_shared` drives ID i.
- R10: Enabling a level-triggered interrupt whose stored input level is high sets it pending for its targets.
- R11: Command encodings on `cmd_op`: 0 enable set, 1 enable clear, 2 pending set, 3 pending clear, 4 priority write (`cmd_data`), 5 trigger write (`cmd_data[0]`, 1 = edge), 6 target write (`cmd_data[NUM_CPU-1:0]`, shared IDs only), 7 no effect. Pending clear on a shared ID clears it for all CPUs.
- R12: A command or line change sampled at clock edge k is visible on `hp_id`/`irq_req` after edge k+2 and not before.
- R13: A command whose `cmd_id` is at or above `NUM_IRQ` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | 1 = legacy level handling, 0 = generic |
| dist_en | input | 1 | Global enable |
| cpu_en | input | NUM_CPU | Per-CPU enable |
| prio_mask | input | NUM_CPU*8 | Per-CPU priority mask, CPU c at bits [c*8+:8] |
| run_prio | input | NUM_CPU*9 | Per-CPU running priority, CPU c at bits [c*9+:9] |
| line_shared | input | NUM_IRQ-32 | Input lines for shared IDs |
| line_private | input | NUM_CPU*32 | Input lines for private IDs |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (R11) |
| cmd_cpu | input | 3 | CPU that a private-ID command addresses |
| cmd_id | input | 10 | Interrupt ID of the command |
| cmd_data | input | 8 | Priority, trigger or target value |
| hp_id | output | NUM_CPU*10 | Highest-pending ID per CPU, CPU c at bits [c*10+:10] |
| irq_req | output | NUM_CPU | Request line per CPU |

## Verification
The assertions assume that `dist_en`, `cpu_en`, `prio_mask` and `run_prio` hold known values from time zero. The bench drives all of them from their declarations and changes them only on falling clock edges. The assertions also treat these inputs as sampled once per edge with a one-edge effect on the outputs, which holds only while nothing else forces the result. That is why the rules they check are the ones that suppress an output outright: a disabled CPU, a zero mask, a zero running priority. The random stimulus issues one command or one line toggle at a time and lets the pipeline drain before comparing with the reference model. It also sends IDs just past `NUM_IRQ`, so the ignore rule is exercised too.

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   legacy_mode,
  input  logic                   dist_en,
  input  logic [NUM_CPU-1:0]     cpu_en,
  input  logic [NUM_CPU*8-1:0]   prio_mask,
  input  logic [NUM_CPU*9-1:0]   run_prio,
  input  logic [NUM_IRQ-33:0]    line_shared,
  input  logic [NUM_CPU*32-1:0]  line_private,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [2:0]             cmd_cpu,
  input  logic [9:0]             cmd_id,
  input  logic [7:0]             cmd_data,
  output logic [NUM_CPU*10-1:0]  hp_id,
  output logic [NUM_CPU-1:0]     irq_req
);
  localparam int NGRP = NUM_IRQ / 32;
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam logic [9:0] NONE = 10'd1023;
  localparam logic [8:0] IDLE = 9'h100;
  localparam logic [9:0] NIRQ = 10'(NUM_IRQ);
  localparam logic [2:0] OP_EN_SET = 3'd0, OP_EN_CLR = 3'd1, OP_PD_SET = 3'd2,
                         OP_PD_CLR = 3'd3, OP_PRIO = 3'd4, OP_TRIG = 3'd5, OP_TGT = 3'd6;

  logic [NUM_IRQ-1:0] en_q [NUM_CPU], en_n [NUM_CPU];
  logic [NUM_IRQ-1:0] pend_q [NUM_CPU], pend_n [NUM_CPU];
  logic [NUM_IRQ-1:0] lvl_q [NUM_CPU], lvl_n [NUM_CPU];
  logic [7:0] prio_q [NUM_CPU][NUM_IRQ], prio_n [NUM_CPU][NUM_IRQ];
  logic [NUM_IRQ-1:0] trig_q, trig_n;
  logic [NUM_CPU-1:0] tgt_q [NUM_IRQ], tgt_n [NUM_IRQ];

  logic [IDX_W-1:0] cidx;
  logic cmd_ok, cmd_priv;
  logic [NUM_CPU-1:0] hit, reach;

  assign cidx     = cmd_id[IDX_W-1:0];
  assign cmd_ok   = cmd_valid && (cmd_id < NIRQ);
  assign cmd_priv = cmd_id < 10'd32;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      hit[c]   = cmd_priv ? (int'(cmd_cpu) == c) : 1'b1;
      reach[c] = cmd_priv ? (int'(cmd_cpu) == c) : tgt_q[cidx][c];
    end
  end

  always_comb begin
    en_n = en_q;
    pend_n = pend_q;
    lvl_n = lvl_q;
    prio_n = prio_q;
    trig_n = trig_q;
    tgt_n = tgt_q;
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int i = 0; i < 32; i++) begin
        if (line_private[c*32+i] != lvl_q[c][i]) begin
          lvl_n[c][i] = line_private[c*32+i];
          if (line_private[c*32+i] && (trig_q[i] || (legacy_mode && en_q[c][i])))
            pend_n[c][i] = 1'b1;
        end
      end
      for (int i = 32; i < NUM_IRQ; i++) begin
        if (line_shared[i-32] != lvl_q[c][i]) begin
          lvl_n[c][i] = line_shared[i-32];
          if (line_shared[i-32] && tgt_q[i][c] && (trig_q[i] || (legacy_mode && en_q[c][i])))
            pend_n[c][i] = 1'b1;
        end
      end
    end
    if (cmd_ok) begin
      for (int c = 0; c < NUM_CPU; c++) begin
        case (cmd_op)
          OP_EN_SET: if (hit[c]) begin
            en_n[c][cidx] = 1'b1;
            if (lvl_q[c][cidx] && !trig_q[cidx] && reach[c]) pend_n[c][cidx] = 1'b1;
          end
          OP_EN_CLR: if (hit[c]) en_n[c][cidx] = 1'b0;
          OP_PD_SET: if (reach[c]) pend_n[c][cidx] = 1'b1;
          OP_PD_CLR: if (hit[c]) pend_n[c][cidx] = 1'b0;
          OP_PRIO:   if (hit[c]) prio_n[c][cidx] = cmd_data;
          default: ;
        endcase
      end
      if (cmd_op == OP_TRIG) trig_n[cidx] = cmd_data[0];
      if (cmd_op == OP_TGT && !cmd_priv) tgt_n[cidx] = cmd_data[NUM_CPU-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '{default: '0};
      pend_q <= '{default: '0};
      lvl_q  <= '{default: '0};
      prio_q <= '{default: '0};
      trig_q <= '0;
      tgt_q  <= '{default: '0};
    end else begin
      en_q   <= en_n;
      pend_q <= pend_n;
      lvl_q  <= lvl_n;
      prio_q <= prio_n;
      trig_q <= trig_n;
      tgt_q  <= tgt_n;
    end
  end

  logic [8:0] gp_d [NUM_CPU][NGRP], gp_q [NUM_CPU][NGRP];
  logic [9:0] gi_d [NUM_CPU][NGRP], gi_q [NUM_CPU][NGRP];

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      for (int g = 0; g < NGRP; g++) begin
        gp_d[c][g] = IDLE;
        gi_d[c][g] = NONE;
        for (int j = 0; j < 32; j++) begin
          if (en_q[c][g*32+j] && pend_q[c][g*32+j] && ({1'b0, prio_q[c][g*32+j]} < gp_d[c][g])) begin
            gp_d[c][g] = {1'b0, prio_q[c][g*32+j]};
            gi_d[c][g] = 10'(g*32+j);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q <= '{default: IDLE};
      gi_q <= '{default: NONE};
    end else begin
      gp_q <= gp_d;
      gi_q <= gi_d;
    end
  end

  logic [8:0] bp [NUM_CPU];
  logic [9:0] bi [NUM_CPU];
  logic [9:0] hp_d [NUM_CPU], hp_q [NUM_CPU];
  logic [NUM_CPU-1:0] req_d, req_q;

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      bp[c] = IDLE;
      bi[c] = NONE;
      for (int g = 0; g < NGRP; g++) begin
        if (gp_q[c][g] < bp[c]) begin
          bp[c] = gp_q[c][g];
          bi[c] = gi_q[c][g];
        end
      end
      hp_d[c] = NONE;
      req_d[c] = 1'b0;
      if (dist_en && cpu_en[c] && (bp[c] < {1'b0, prio_mask[c*8 +: 8]})) begin
        hp_d[c] = bi[c];
        req_d[c] = bp[c] < run_prio[c*9 +: 9];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_q  <= '{default: NONE};
      req_q <= '0;
    end else begin
      hp_q  <= hp_d;
      req_q <= req_d;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
    assign hp_id[c*10 +: 10] = hp_q[c];
  end
  assign irq_req = req_q;

endmodule

// File: rtl/irq_prio_arb_chk.sv
module irq_prio_arb_chk #(
  parameter int NUM_CPU = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  dist_en,
  input logic [NUM_CPU-1:0]    cpu_en,
  input logic [NUM_CPU*8-1:0]  prio_mask,
  input logic [NUM_CPU*9-1:0]  run_prio,
  input logic [NUM_CPU*10-1:0] hp_id,
  input logic [NUM_CPU-1:0]    irq_req
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dist_en && cpu_en[c]) |-> (!irq_req[c] && hp_id[c*10 +: 10] == 10'd1023));
    assert_req_has_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[c] |-> hp_id[c*10 +: 10] != 10'd1023);
    assert_zero_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(prio_mask[c*8 +: 8]) == 8'd0 |-> hp_id[c*10 +: 10] == 10'd1023);
    assert_zero_run_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_prio[c*9 +: 9]) == 9'd0 |-> !irq_req[c]);
  end
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
  .prio_mask(prio_mask), .run_prio(run_prio), .hp_id(hp_id), .irq_req(irq_req)
);

// File: tb/irq_prio_arb_test.sv
module irq_prio_arb_test;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 64;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic legacy = 1'b0;
  logic dist_en = 1'b0;
  logic [NC-1:0] cpu_en = '0;
  logic [NC*8-1:0] prio_mask = '0;
  logic [NC*9-1:0] run_prio = '0;
  logic [NI-33:0] line_shared = '0;
  logic [NC*32-1:0] line_private = '0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [2:0] cmd_cpu = '0;
  logic [9:0] cmd_id = '0;
  logic [7:0] cmd_data = '0;
  logic [NC*10-1:0] hp_id;
  logic [NC-1:0] irq_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arb #(.NUM_IRQ(NI), .NUM_CPU(NC)) uut (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy), .dist_en(dist_en), .cpu_en(cpu_en),
    .prio_mask(prio_mask), .run_prio(run_prio), .line_shared(line_shared),
    .line_private(line_private), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cpu(cmd_cpu),
    .cmd_id(cmd_id), .cmd_data(cmd_data), .hp_id(hp_id), .irq_req(irq_req)
  );

  int checks = 0;
  int errors = 0;

  bit m_en [NC][NI];
  bit m_pend [NC][NI];
  bit m_lvl [NC][NI];
  bit [7:0] m_prio [NC][NI];
  bit m_trig [NI];
  bit [NC-1:0] m_tgt [NI];

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NI; i++) begin
        m_en[c][i] = 0; m_pend[c][i] = 0; m_lvl[c][i] = 0; m_prio[c][i] = 0;
      end
    for (int i = 0; i < NI; i++) begin m_trig[i] = 0; m_tgt[i] = '0; end
  endtask

  function automatic int exp_hp(int c);
    int bp, bi;
    bp = 256; bi = 1023;
    if (!dist_en || !cpu_en[c]) return 1023;
    for (int i = 0; i < NI; i++)
      if (m_en[c][i] && m_pend[c][i] && int'(m_prio[c][i]) < bp) begin bp = m_prio[c][i]; bi = i; end
    return (bp < int'(prio_mask[c*8 +: 8])) ? bi : 1023;
  endfunction

  function automatic bit exp_req(int c);
    int h;
    h = exp_hp(c);
    if (h == 1023) return 0;
    return int'(m_prio[c][h]) < int'(run_prio[c*9 +: 9]);
  endfunction

  task automatic m_line(int c, int id, bit v);
    if (v != m_lvl[c][id]) begin
      m_lvl[c][id] = v;
      if (v && (id < 32 || m_tgt[id][c]) && (m_trig[id] || (legacy && m_en[c][id])))
        m_pend[c][id] = 1;
    end
  endtask

  task automatic m_cmd(int op, int cpu, int id, int data);
    bit priv, hit, reach;
    if (id >= NI) return;
    priv = id < 32;
    for (int c = 0; c < NC; c++) begin
      hit = priv ? (cpu == c) : 1'b1;
      reach = priv ? (cpu == c) : m_tgt[id][c];
      case (op)
        0: if (hit) begin
             m_en[c][id] = 1;
             if (m_lvl[c][id] && !m_trig[id] && reach) m_pend[c][id] = 1;
           end
        1: if (hit) m_en[c][id] = 0;
        2: if (reach) m_pend[c][id] = 1;
        3: if (hit) m_pend[c][id] = 0;
        4: if (hit) m_prio[c][id] = data[7:0];
        default: ;
      endcase
    end
    if (op == 5) m_trig[id] = data[0];
    if (op == 6 && !priv) m_tgt[id] = data[NC-1:0];
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(int op, int cpu, int id, int data);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op[2:0]; cmd_cpu = cpu[2:0]; cmd_id = id[9:0]; cmd_data = data[7:0];
    @(negedge clk);
    cmd_valid = 0;
    m_cmd(op, cpu, id, data);
    settle();
  endtask

  task automatic sh_line(int id, bit v);
    @(negedge clk);
    line_shared[id-32] = v;
    for (int c = 0; c < NC; c++) m_line(c, id, v);
    settle();
  endtask

  task automatic pv_line(int c, int id, bit v);
    @(negedge clk);
    line_private[c*32+id] = v;
    m_line(c, id, v);
    settle();
  endtask

  function automatic int hp(int c);
    return int'(hp_id[c*10 +: 10]);
  endfunction

  task automatic check_all(string tag);
    for (int c = 0; c < NC; c++) begin
      chk(hp(c) == exp_hp(c), {tag, " hp"}, hp(c), exp_hp(c));
      chk(irq_req[c] == exp_req(c), {tag, " req"}, int'(irq_req[c]), int'(exp_req(c)));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    line_shared = '0; line_private = '0;
    m_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(hp(c) == 1023, "R1 reset hp", hp(c), 1023);
      chk(irq_req[c] == 0, "R1 reset req", int'(irq_req[c]), 0);
    end

    dist_en = 1; cpu_en = '1; prio_mask = {8'hff, 8'hff}; run_prio = {9'h100, 9'h100};
    settle();
    check_all("R3 idle");
    foreach (m_tgt[i]) if (i == 35 || i == 40 || i == 41 || i == 33) cmd(6, 0, i, 3);
    cmd(4, 0, 40, 8'h20); cmd(4, 0, 41, 8'h20); cmd(4, 0, 35, 8'h30); cmd(4, 0, 33, 8'h10);
    cmd(0, 0, 40, 0); cmd(0, 0, 41, 0); cmd(0, 0, 35, 0); cmd(0, 0, 33, 0);
    cmd(2, 0, 35, 0);
    chk(hp(0) == 35, "R2 single", hp(0), 35);
    cmd(2, 0, 41, 0);
    chk(hp(1) == 41, "R2 lower prio", hp(1), 41);
    cmd(2, 0, 40, 0);
    chk(hp(0) == 40, "R2 tie lowest id", hp(0), 40);
    check_all("R2 model");

    prio_mask[7:0] = 8'h20; settle();
    chk(hp(0) == 1023, "R5 mask equal", hp(0), 1023);
    chk(hp(1) == 40, "R5 other cpu", hp(1), 40);
    prio_mask[7:0] = 8'h21; settle();
    chk(hp(0) == 40 && irq_req[0], "R5 mask above", hp(0), 40);
    run_prio[8:0] = 9'h020; settle();
    chk(hp(0) == 40 && !irq_req[0], "R5 run equal", int'(irq_req[0]), 0);
    run_prio[8:0] = 9'h021; settle();
    chk(irq_req[0] == 1, "R5 run above", int'(irq_req[0]), 1);
    run_prio[8:0] = 9'h100; prio_mask[7:0] = 8'hff;

    dist_en = 0; settle();
    check_all("R4 global off");
    chk(hp(1) == 1023, "R4 global off hp", hp(1), 1023);
    dist_en = 1; cpu_en = 2'b01; settle();
    chk(hp(1) == 1023 && hp(0) == 40, "R4 cpu off", hp(1), 1023);
    cpu_en = 2'b11; settle();

    cmd(3, 0, 40, 0);
    chk(hp(0) == 41 && hp(1) == 41, "R11 clear all cpus", hp(1), 41);

    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd2; cmd_id = 10'd33; cmd_data = 0;
    @(negedge clk);
    cmd_valid = 0; m_cmd(2, 0, 33, 0);
    chk(hp(0) == 41, "R12 edge k", hp(0), 41);
    @(negedge clk);
    chk(hp(0) == 41, "R12 edge k+1", hp(0), 41);
    @(negedge clk);
    chk(hp(0) == 33, "R12 edge k+2", hp(0), 33);

    cmd(4, 0, 5, 8'h05); cmd(0, 0, 5, 0); cmd(2, 0, 5, 0);
    chk(hp(0) == 5 && hp(1) == 33, "R8 private per cpu", hp(1), 33);
    cmd(6, 0, 50, 2); cmd(4, 0, 50, 1); cmd(0, 0, 50, 0); cmd(2, 0, 50, 0);
    chk(hp(1) == 50 && hp(0) == 5, "R9 target mask", hp(0), 5);
    cmd(2, 0, 64, 0); cmd(4, 0, 70, 0);
    chk(hp(0) == 5 && hp(1) == 50, "R13 id out of range", hp(1), 50);
    check_all("R13 model");

    cmd(3, 0, 5, 0); cmd(3, 0, 50, 0); cmd(3, 0, 33, 0); cmd(3, 0, 41, 0); cmd(3, 0, 35, 0);
    chk(hp(0) == 1023 && hp(1) == 1023 && irq_req == 0, "R3 none pending", hp(0), 1023);

    cmd(6, 0, 60, 1); cmd(4, 0, 60, 2); cmd(0, 0, 60, 0);
    legacy = 0;
    sh_line(60, 1);
    chk(hp(0) == 1023, "R7 generic level", hp(0), 1023);
    sh_line(60, 0);
    legacy = 1;
    sh_line(60, 1);
    chk(hp(0) == 60, "R7 legacy level", hp(0), 60);
    cmd(3, 0, 60, 0); settle();
    chk(hp(0) == 1023, "R6 held line no repend", hp(0), 1023);
    sh_line(60, 0);
    legacy = 0;
    cmd(6, 0, 61, 1); cmd(4, 0, 61, 3); cmd(5, 0, 61, 1); cmd(0, 0, 61, 0);
    sh_line(61, 1);
    chk(hp(0) == 61, "R6 edge rising", hp(0), 61);
    cmd(3, 0, 61, 0);
    cmd(6, 0, 62, 3); cmd(4, 0, 62, 4);
    sh_line(62, 1);
    chk(hp(0) == 1023, "R10 line high disabled", hp(0), 1023);
    cmd(0, 0, 62, 0);
    chk(hp(0) == 62 && hp(1) == 62, "R10 enable pends", hp(1), 62);
    cmd(5, 0, 7, 1); cmd(0, 1, 7, 0);
    pv_line(1, 7, 1);
    chk(hp(1) == 7 && hp(0) == 62, "R8 private line", hp(1), 7);
    check_all("R8 model");

    do_reset();
    settle();
    check_all("R1 second reset");
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r <= 5) cmd(int'($urandom_range(0, 7)), int'($urandom_range(0, NC-1)),
                      int'($urandom_range(0, NI+6)), int'($urandom_range(0, 255)));
      else if (r == 6) begin
        int id;
        id = int'($urandom_range(32, NI-1));
        sh_line(id, ~line_shared[id-32]);
      end else if (r == 7) begin
        int c, id;
        c = int'($urandom_range(0, NC-1)); id = int'($urandom_range(0, 31));
        pv_line(c, id, ~line_private[c*32+id]);
      end else if (r == 8) begin
        for (int c = 0; c < NC; c++) begin
          prio_mask[c*8 +: 8] = 8'($urandom_range(0, 255));
          run_prio[c*9 +: 9] = 9'($urandom_range(0, 256));
        end
        settle();
      end else begin
        legacy = 1'($urandom_range(0, 1));
        cpu_en = ($urandom_range(0, 3) == 0) ? NC'($urandom) : '1;
        dist_en = $urandom_range(0, 7) != 0;
        settle();
      end
      check_all("R2 R7 R9 R11 random");
    end
    finish_run();
  end
endmodule